// File: doc/BRIEF.md
# Interrupt State Register Bank

This block keeps the per-interrupt configuration of an interrupt distributor for `NUM_IRQ` interrupt IDs. For every ID it stores six items: a group bit, an enable bit, a pending bit, an active bit, a priority narrowed to `PRI_BITS` implemented bits, and an edge/level trigger flag. Software reaches all of it through a small register bus. The bus carries an address, a byte length of 1, 2 or 4, write data, a write strobe and a read strobe, and it returns registered read data.

Enable, pending and active each have two windows: one that sets bits and one that clears bits. Only the 1 bits of a write act in either window. Both windows of a bank return the same current state on a read. The group bits form a plain read/write bank. Priorities take one byte lane per ID. Trigger configuration takes a two-bit field per ID. The 32 private IDs keep a fixed level trigger.

Top module: `irqd_state_bank`

## Requirements
- R1: After reset every group, enable, pending and active bit is 0, every priority is 0 and every ID is level-triggered, so every mapped read returns 0.
- R2: Windows sit at these byte offsets: group 0x000, enable-set 0x080, enable-clear 0x100, pending-set 0x180, pending-clear 0x200, active-set 0x280, active-clear 0x300, configuration 0x400, priority 0x800. Bit k of an access at offset o into a one-bit window maps to ID 8·o+k. A read of the set window or the clear window of a bank returns the same current bits.
- R3: A write to a set window sets the bit of each ID whose data bit is 1. IDs whose data bit is 0 keep their state.
- R4: A write to a clear window clears the bit of each ID whose data bit is 1. IDs whose data bit is 0 keep their state.
- R5: The pending and active banks behave like the enable bank, and each of the three banks is independent of the other two.
- R6: A write to the group window stores every covered data bit as given, 0 or 1.
- R7: The priority window holds one byte per ID at offset 0x800+ID. In a multi-byte access, byte k at data bits [8k+7:8k] belongs to ID first+k.
- R8: A priority write keeps only the top `PRI_BITS` bits of each byte and zeroes the rest. A read returns the narrowed value.
- R9: The configuration window gives ID 4·o+k the field at data bits [2k+1:2k] for offset o. The upper bit is 1 for edge and 0 for level. The lower bit reads 0, and writes to it have no effect.
- R10: Configuration writes to IDs 0 to 31 are ignored, so those IDs always read as level-triggered.
- R11: A read drives `reg_rdata` on the clock edge that samples `reg_rd`. `reg_rdata` holds its value in cycles with no read.
- R12: Only the low 8·len data bits take part in an access, and read bits above them return 0. An access with a length other than 1, 2 or 4, or at an address that is not a multiple of its length, writes nothing and reads 0.
- R13: IDs at or above `NUM_IRQ` and unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_len | input | 3 | Access length in bytes (1, 2 or 4) |
| reg_wdata | input | 32 | Write data, ID lanes from bit 0 |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, never together with reg_wr |
| reg_rdata | output | 32 | Registered read data |

## Verification
One write often reaches several IDs at once. Some get a 1 data bit and must change, some get a 0 data bit and must keep their state, and some lie past `NUM_IRQ` or in the private range and must not move. The bench provokes this with directed words of mixed bits placed at bank edges. It adds seeded random writes of every length into every window, each followed by reads of both windows of the bank. Each read is judged against a bench model of all six state items, so a lane that was wrongly written or wrongly left alone shows up at the next read.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [3:0] {
    RG_NONE, RG_GRP, RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD,
    RG_SETAC, RG_CLRAC, RG_CFG, RG_PRI
  } region_e;

  localparam int BIT_WIN  = 'h080;
  localparam int BIT_END  = 'h380;
  localparam int CFG_BASE = 'h400;
  localparam int CFG_WIN  = 'h100;
  localparam int PRI_BASE = 'h800;
  localparam int PRI_WIN  = 'h400;
  localparam int PRIV_IDS = 32;
  localparam int BUS_W    = 32;
endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDW    = ADDR_W + 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        len,
  output region_e           region,
  output logic [IDW-1:0]    first_id,
  output logic [5:0]        lanes
);
  int a, l, first, ln;
  logic ok;

  always_comb begin
    a      = int'(addr);
    l      = int'(len);
    ok     = (l == 1 || l == 2 || l == 4) && ((a % (l == 0 ? 1 : l)) == 0);
    region = RG_NONE;
    first  = 0;
    ln     = 0;
    if (ok) begin
      if (a < BIT_END) begin
        case (a / BIT_WIN)
          0:       region = RG_GRP;
          1:       region = RG_SETEN;
          2:       region = RG_CLREN;
          3:       region = RG_SETPD;
          4:       region = RG_CLRPD;
          5:       region = RG_SETAC;
          default: region = RG_CLRAC;
        endcase
        first = (a % BIT_WIN) * 8;
        ln    = l * 8;
      end else if (a >= CFG_BASE && a < CFG_BASE + CFG_WIN) begin
        region = RG_CFG;
        first  = (a - CFG_BASE) * 4;
        ln     = l * 4;
      end else if (a >= PRI_BASE && a < PRI_BASE + PRI_WIN) begin
        region = RG_PRI;
        first  = a - PRI_BASE;
        ln     = l;
      end
    end
    first_id = IDW'(first);
    lanes    = 6'(ln);
  end
endmodule

// File: rtl/irqd_bitbank.sv
module irqd_bitbank
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDW     = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_load,
  input  logic [IDW-1:0]   first_id,
  input  logic [5:0]       lanes,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rd_word
);
  localparam int IW = $clog2(NUM_IRQ);
  logic [NUM_IRQ-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        int k;
        k = n - int'(first_id);
        if (k >= 0 && k < int'(lanes)) begin
          if (wr_load)                     st_q[n] <= wdata[5'(k)];
          else if (wr_set && wdata[5'(k)]) st_q[n] <= 1'b1;
          else if (wr_clr && wdata[5'(k)]) st_q[n] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < BUS_W; k++) begin
      int id;
      id = int'(first_id) + k;
      if (k < int'(lanes) && id < NUM_IRQ) rd_word[k] = st_q[IW'(id)];
    end
  end

  // R3
  set_only_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (($past(st_q) & ~st_q) == '0));
  // R4
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((~$past(st_q) & st_q) == '0));
  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_set || wr_clr || wr_load) |=> $stable(st_q));
endmodule

// File: rtl/irqd_prio.sv
module irqd_prio
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRI_BITS = 5,
  parameter int IDW      = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDW-1:0]   first_id,
  input  logic [5:0]       lanes,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rd_word
);
  localparam int IW = $clog2(NUM_IRQ);
  logic [PRI_BITS-1:0] prio_q [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NUM_IRQ; n++) prio_q[n] <= '0;
    end else if (wr) begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        int k;
        logic [BUS_W-1:0] sh;
        k  = n - int'(first_id);
        sh = wdata >> (8 * (k & 3));
        if (k >= 0 && k < int'(lanes)) prio_q[n] <= sh[7 -: PRI_BITS];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      int id;
      logic [7:0] b;
      id = int'(first_id) + k;
      b  = '0;
      if (k < int'(lanes) && id < NUM_IRQ) b[7 -: PRI_BITS] = prio_q[IW'(id)];
      rd_word[8*k +: 8] = b;
    end
  end

  // R7
  prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(prio_q[0]) && $stable(prio_q[NUM_IRQ-1])));
endmodule

// File: rtl/irqd_cfg.sv
module irqd_cfg
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDW     = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDW-1:0]   first_id,
  input  logic [5:0]       lanes,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rd_word
);
  localparam int IW = $clog2(NUM_IRQ);
  logic [NUM_IRQ-1:0] edge_q;

  always_ff @(posedge clk) begin
    if (rst) edge_q <= '0;
    else if (wr) begin
      for (int n = PRIV_IDS; n < NUM_IRQ; n++) begin
        int k;
        k = n - int'(first_id);
        if (k >= 0 && k < int'(lanes)) edge_q[n] <= wdata[5'(2 * k + 1)];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < BUS_W / 2; k++) begin
      int id;
      id = int'(first_id) + k;
      if (k < int'(lanes) && id < NUM_IRQ) rd_word[2*k+1] = edge_q[IW'(id)];
    end
  end

  // R10
  cfg_private_chk: assert property (@(posedge clk) disable iff (rst)
    edge_q[PRIV_IDS-1:0] == '0);
endmodule

// File: rtl/irqd_state_bank.sv
module irqd_state_bank
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRI_BITS = 5,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [2:0]        reg_len,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata
);
  localparam int IDW   = ADDR_W + 3;
  localparam int NBANK = 4;

  region_e        region;
  logic [IDW-1:0] first_id;
  logic [5:0]     lanes;
  logic [BUS_W-1:0] bank_rd [NBANK];
  logic [BUS_W-1:0] pri_rd, cfg_rd, rd_d;

  irqd_decode #(.ADDR_W(ADDR_W), .IDW(IDW)) u_dec (
    .addr(reg_addr), .len(reg_len), .region(region),
    .first_id(first_id), .lanes(lanes));

  // bank 0 group, 1 enable, 2 pending, 3 active
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic ws, wc, wl;
    assign wl = reg_wr && (b == 0) && (region == RG_GRP);
    assign ws = reg_wr && (b != 0) && (region == region_e'(2 * b));
    assign wc = reg_wr && (b != 0) && (region == region_e'(2 * b + 1));
    irqd_bitbank #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_bank (
      .clk(clk), .rst(rst), .wr_set(ws), .wr_clr(wc), .wr_load(wl),
      .first_id(first_id), .lanes(lanes), .wdata(reg_wdata),
      .rd_word(bank_rd[b]));
  end

  irqd_prio #(.NUM_IRQ(NUM_IRQ), .PRI_BITS(PRI_BITS), .IDW(IDW)) u_pri (
    .clk(clk), .rst(rst), .wr(reg_wr && region == RG_PRI),
    .first_id(first_id), .lanes(lanes), .wdata(reg_wdata), .rd_word(pri_rd));

  irqd_cfg #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr && region == RG_CFG),
    .first_id(first_id), .lanes(lanes), .wdata(reg_wdata), .rd_word(cfg_rd));

  always_comb begin
    case (region)
      RG_GRP:             rd_d = bank_rd[0];
      RG_SETEN, RG_CLREN: rd_d = bank_rd[1];
      RG_SETPD, RG_CLRPD: rd_d = bank_rd[2];
      RG_SETAC, RG_CLRAC: rd_d = bank_rd[3];
      RG_CFG:             rd_d = cfg_rd;
      RG_PRI:             rd_d = pri_rd;
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_d;
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  // R11
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));
endmodule

// File: tb/irqd_state_bank_bench.sv
module irqd_state_bank_bench;
  localparam int NUM_IRQ  = 64;
  localparam int PRI_BITS = 5;
  localparam int ADDR_W   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [2:0]  reg_len = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit m_bit [4][NUM_IRQ];
  bit m_edge [NUM_IRQ];
  logic [7:0] m_pri [NUM_IRQ];

  always #4 clk = ~clk;

  irqd_state_bank #(.NUM_IRQ(NUM_IRQ), .PRI_BITS(PRI_BITS), .ADDR_W(ADDR_W))
    u_irqd_state_bank (.clk(clk), .rst(rst), .reg_addr(reg_addr),
      .reg_len(reg_len), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // kind: 0 none, 1 group, 2 set, 3 clear, 4 cfg, 5 prio; bank for kinds 1-3
  function automatic void decode(input int a, input int l, output int kind,
                                 output int bank, output int first, output int ln);
    kind = 0; bank = 0; first = 0; ln = 0;
    if (!(l == 1 || l == 2 || l == 4) || (a % l) != 0) return;
    if (a < 'h380) begin
      int w;
      w = a / 'h80;
      if (w == 0) kind = 1;
      else begin bank = (w + 1) / 2; kind = (w % 2 == 1) ? 2 : 3; end
      first = (a % 'h80) * 8; ln = l * 8;
    end else if (a >= 'h400 && a < 'h500) begin
      kind = 4; first = (a - 'h400) * 4; ln = l * 4;
    end else if (a >= 'h800 && a < 'hC00) begin
      kind = 5; first = a - 'h800; ln = l;
    end
  endfunction

  function automatic logic [31:0] exp_read(input int a, input int l);
    int kind, bank, first, ln;
    logic [31:0] r;
    r = '0;
    decode(a, l, kind, bank, first, ln);
    for (int k = 0; k < ln; k++) begin
      int id;
      id = first + k;
      if (id < NUM_IRQ) begin
        if (kind >= 1 && kind <= 3) r[k] = m_bit[bank][id];
        else if (kind == 4) r[2*k+1] = m_edge[id];
        else if (kind == 5) r[8*k +: 8] = m_pri[id];
      end
    end
    return r;
  endfunction

  function automatic void model_write(input int a, input int l, input logic [31:0] d);
    int kind, bank, first, ln;
    logic [7:0] msk;
    msk = 8'hFF << (8 - PRI_BITS);
    decode(a, l, kind, bank, first, ln);
    for (int k = 0; k < ln; k++) begin
      int id;
      id = first + k;
      if (id < NUM_IRQ) begin
        if (kind == 1) m_bit[0][id] = d[k];
        else if (kind == 2 && d[k]) m_bit[bank][id] = 1'b1;
        else if (kind == 3 && d[k]) m_bit[bank][id] = 1'b0;
        else if (kind == 4 && id >= 32) m_edge[id] = d[2*k+1];
        else if (kind == 5) m_pri[id] = d[8*k +: 8] & msk;
      end
    end
  endfunction

  task automatic wr(input int a, input int l, input logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a); reg_len = 3'(l); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(a, l, d);
  endtask

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, input int l, input string tag);
    @(negedge clk);
    reg_addr = ADDR_W'(a); reg_len = 3'(l); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata, exp_read(a, l), tag);
  endtask

  initial begin
    logic [31:0] held;
    for (int i = 0; i < NUM_IRQ; i++) begin
      for (int b = 0; b < 4; b++) m_bit[b][i] = 1'b0;
      m_edge[i] = 1'b0; m_pri[i] = '0;
    end
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset
    rd('h084, 4, "R1 enable");  check(reg_rdata, 0, "R1 enable zero");
    rd('h804, 4, "R1 prio");    rd('h40C, 4, "R1 cfg");
    // R3 / R2
    wr('h080, 4, 32'h0000_00F0); rd('h080, 4, "R3 set");
    check(reg_rdata, 32'h0000_00F0, "R3 set value");
    wr('h080, 4, 32'h0000_000F); rd('h100, 4, "R2 clr view");
    check(reg_rdata, 32'h0000_00FF, "R2 same view");
    // R4
    wr('h100, 4, 32'h0000_0030); rd('h080, 4, "R4 clear");
    check(reg_rdata, 32'h0000_00CF, "R4 clear value");
    // R5
    wr('h184, 4, 32'h0000_A5A5); rd('h204, 4, "R5 pend");
    check(reg_rdata, 32'h0000_A5A5, "R5 pend value");
    rd('h084, 4, "R5 enable untouched");
    wr('h280, 4, 32'hFFFF_FFFF); wr('h300, 4, 32'h0000_FFFF);
    rd('h280, 4, "R5 active"); check(reg_rdata, 32'hFFFF_0000, "R5 active value");
    // R6
    wr('h004, 4, 32'h1234_5678); wr('h004, 4, 32'h0000_0001);
    rd('h004, 4, "R6 group"); check(reg_rdata, 32'h0000_0001, "R6 group value");
    // R7 R8
    wr('h800, 4, 32'hFFEE_DDCC); rd('h800, 4, "R8 narrow");
    check(reg_rdata, 32'hF8E8_D8C8, "R8 narrow value");
    wr('h805, 1, 32'h0000_007F); wr('h806, 2, 32'h0000_ABCD);
    rd('h804, 4, "R7 lanes"); check(reg_rdata, 32'hA8C8_7800, "R7 lanes value");
    // R9 R10
    wr('h408, 4, 32'hFFFF_FFFF); rd('h408, 4, "R9 cfg");
    check(reg_rdata, 32'hAAAA_AAAA, "R9 cfg value");
    wr('h408, 4, 32'h0000_0002); rd('h408, 4, "R9 cfg single");
    wr('h400, 4, 32'hFFFF_FFFF); rd('h400, 4, "R10 private");
    check(reg_rdata, 32'h0, "R10 private value");
    // R12
    wr('h181, 1, 32'hFFFF_FFFF); rd('h180, 4, "R12 byte write");
    check(reg_rdata, 32'h0000_FF00, "R12 byte write value");
    rd('h181, 1, "R12 byte read"); check(reg_rdata, 32'h0000_00FF, "R12 byte read value");
    wr('h182, 4, 32'hFFFF_FFFF); wr('h280, 3, 32'hFFFF_FFFF);
    rd('h180, 4, "R12 unaligned ignored"); rd('h280, 4, "R12 bad len ignored");
    // R13
    wr('h088, 4, 32'hFFFF_FFFF); rd('h088, 4, "R13 high ids");
    check(reg_rdata, 32'h0, "R13 high ids value");
    wr('h840, 1, 32'hFF); rd('h840, 4, "R13 prio high");
    rd('h700, 4, "R13 unmapped");
    // R11 hold
    rd('h804, 4, "R11 read"); held = reg_rdata;
    wr('h804, 4, 32'h0); repeat (3) @(negedge clk);
    check(reg_rdata, held, "R11 hold");

    // random mix
    for (int t = 0; t < 400; t++) begin
      int r, l, span, base, off, a;
      r = $urandom % 9;
      l = (($urandom % 3) == 0) ? 1 : ((($urandom % 2) == 0) ? 2 : 4);
      if (r < 7) begin base = r * 'h80; span = 12; end
      else if (r == 7) begin base = 'h400; span = 24; end
      else begin base = 'h800; span = 96; end
      off = ($urandom % span) & ~(l - 1);
      a = base + off;
      wr(a, l, $urandom);
      rd(a, l, "R3 R4 R5 R6 R7 R9 random");
      if (r >= 1 && r < 7)
        rd((r % 2 == 1) ? a + 'h80 : a - 'h80, l, "R2 random pair view");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule